// File: doc/BRIEF.md
# Multichannel SPI Master Controller

This block is a register-mapped SPI master that serves up to four chip-select channels through one shared shift engine. Each channel owns a small register bank holding its clock polarity and phase, a power-of-two clock divider, the word length (4 to 32 bits), the active level of its chip select, a transfer mode and an enable bit. Software writes a word to a channel's transmit register. The engine then shifts it out MSB-first on `mosi` while it clocks the reply in from `miso`. Software polls the channel status for the receive-ready, transmit-empty and end-of-transfer flags.

A channel in receive-only mode starts on one write to its transmit register. It then keeps clocking in words, sending that written word as filler, until software clears its enable bit. A channel in transmit-only mode discards what it receives. A force bit holds the chip select active across several words, so that one device sees them as a single frame. When several channels have work pending, the lowest-numbered channel is served first.

The register port has a valid/ready request side. `req_ready` is always high, so a request is taken in the cycle it is presented and there is never back-pressure. Every read request returns exactly one `rsp_valid` pulse, with its data, in the following cycle. Writes return no response. The response side has no ready input, so the requester must accept the data in that cycle.

Top module: `mspi_ctrl`

## Requirements
- R1: The module control register sits at byte address 0x28 and stores bits 0, 2 and 3 (bit 1 reads 0). Channel i's registers start at 0x2C + 0x14*i: configuration at +0x0, status at +0x4, enable at +0x8, transmit at +0xC and receive at +0x10. Other addresses read 0. A read is answered with `rsp_valid` and its data in the next cycle, and a write produces no response.
- R2: After reset, every status register reads 0x2 (transmit empty only), and every configuration and enable register reads 0.
- R3: Configuration bit 0 is the clock phase and bit 1 is the clock polarity. `sclk` returns to the polarity level after every word. With phase 0, `miso` is sampled on the leading edges. With phase 1, it is sampled on the trailing edges. The word is sent MSB-first. With `miso` tied to `mosi`, the received word equals the sent word.
- R4: Configuration bits 5:2 hold a divider exponent d. Each `sclk` half period lasts 2^d clock cycles. An unforced chip select is active for exactly 2*L*2^d cycles per word of length L.
- R5: Configuration bits 11:7 hold the word length minus one. Field values below 3 give a length of 4. The received word is right-justified in the receive register, and its upper bits read 0.
- R6: When configuration bit 6 is set, `cs_o[i]` is active low, and otherwise it is active high. An idle channel drives its inactive level.
- R7: Configuration bit 20 holds the channel's chip select active for as long as the bit is set, whether or not a word is shifting.
- R8: Enable register bit 0 gates the channel. No shifting happens while it is clear. A word written while the channel is disabled starts once the channel is enabled.
- R9: Status bit 0 (receive ready) is set at the end of a word and cleared by a receive read. Bit 1 (transmit empty) is cleared by a transmit write and set when the word moves into the shifter. Bit 2 (end of transfer) is cleared by a transmit write and set at the end of the word.
- R10: Configuration bits 13:12 select the mode: 00 full duplex, 01 receive-only, 10 transmit-only. In transmit-only mode, receive ready never sets and the receive register keeps its old value. In receive-only mode, one transmit write starts words back to back until the channel is disabled.
- R11: Only one channel shifts at a time. Among channels with work pending, the lowest index starts first, and no two unforced chip selects are ever active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Per-channel chip selects |

## Verification
Read data is due in the cycle after the request, so the bench samples it at the falling edge that ends that cycle. A scoreboard pops the expected receive word there. Flag updates arrive a fixed few cycles after a word ends, but the word length depends on d and L. For that reason the bench polls the status register instead of waiting a fixed time, and it checks flag values only once polling has seen the word finish. The timing of the serial side is checked by counting, at every falling edge, the cycles in which each chip select is active and the `sclk` transitions. These counts are compared against 2*L*2^d and 2*L. A record of the order in which channels become active confirms the priority rule.

// File: rtl/mspi_pkg.sv
package mspi_pkg;
  localparam logic [7:0] MODCTL_ADR = 8'h28;
  localparam logic [7:0] CH0_ADR    = 8'h2C;
  localparam logic [7:0] CH_STRIDE  = 8'h14;
  localparam logic [7:0] OFS_CONF   = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_TX     = 8'h0C;
  localparam logic [7:0] OFS_RX     = 8'h10;

  typedef enum logic [1:0] {
    XF_DUPLEX = 2'b00,
    XF_RXONLY = 2'b01,
    XF_TXONLY = 2'b10,
    XF_RSVD   = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic       cpha;
    logic       cpol;
    logic [3:0] div;
    logic [5:0] len;
  } shift_cfg_t;
endpackage

// File: rtl/mspi_chan.sv
module mspi_chan
  import mspi_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter logic [7:0]  BASE = 8'h2C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [7:0]    acc_addr,
  input  logic [DW-1:0] acc_wdata,
  input  logic          start_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_word_i,
  output logic [DW-1:0] rdata_o,
  output logic          req_o,
  output logic          en_o,
  output logic          txe_o,
  output shift_cfg_t    cfg_o,
  output logic [DW-1:0] tx_word_o,
  output logic          force_o,
  output logic          lowact_o
);
  localparam int unsigned CFG_W   = 21;
  localparam logic [8:0]  END_ADR = {1'b0, BASE} + {1'b0, CH_STRIDE};

  logic [CFG_W-1:0] conf_q;
  logic [DW-1:0]    tx_q, rx_q;
  logic             en_q, rxs_q, txs_q, eot_q, rxrun_q;
  logic             in_rng;
  logic [7:0]       off;
  logic             wr_conf, wr_ctrl, wr_tx, rd_rx;
  xfer_mode_e       mode;
  logic [4:0]       wl;

  assign in_rng  = (acc_addr >= BASE) && ({1'b0, acc_addr} < END_ADR);
  assign off     = acc_addr - BASE;
  assign wr_conf = acc_valid && acc_write && in_rng && (off == OFS_CONF);
  assign wr_ctrl = acc_valid && acc_write && in_rng && (off == OFS_CTRL);
  assign wr_tx   = acc_valid && acc_write && in_rng && (off == OFS_TX);
  assign rd_rx   = acc_valid && !acc_write && in_rng && (off == OFS_RX);

  assign mode = xfer_mode_e'(conf_q[13:12]);
  assign wl   = conf_q[11:7];

  always_comb begin
    cfg_o.cpha = conf_q[0];
    cfg_o.cpol = conf_q[1];
    cfg_o.div  = conf_q[5:2];
    cfg_o.len  = (wl < 5'd3) ? 6'd4 : ({1'b0, wl} + 6'd1);
  end

  assign force_o   = conf_q[20];
  assign lowact_o  = conf_q[6];
  assign tx_word_o = tx_q;
  assign en_o      = en_q;
  assign txe_o     = txs_q;
  assign req_o     = en_q && (!txs_q || rxrun_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      en_q    <= 1'b0;
      rxs_q   <= 1'b0;
      txs_q   <= 1'b1;
      eot_q   <= 1'b0;
      rxrun_q <= 1'b0;
    end else begin
      if (wr_conf) begin
        conf_q  <= acc_wdata[CFG_W-1:0];
        rxrun_q <= 1'b0;
      end
      if (wr_ctrl) begin
        en_q <= acc_wdata[0];
        if (!acc_wdata[0]) rxrun_q <= 1'b0;
      end
      if (start_i) txs_q <= 1'b1;
      if (rd_rx)   rxs_q <= 1'b0;
      if (done_i) begin
        eot_q <= 1'b1;
        if (mode != XF_TXONLY) begin
          rx_q  <= rx_word_i;
          rxs_q <= 1'b1;
        end
      end
      if (wr_tx) begin
        tx_q    <= acc_wdata;
        txs_q   <= 1'b0;
        eot_q   <= 1'b0;
        rxrun_q <= (mode == XF_RXONLY);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_rng) begin
      case (off)
        OFS_CONF: rdata_o = {{(DW-CFG_W){1'b0}}, conf_q};
        OFS_STAT: rdata_o = {{(DW-3){1'b0}}, eot_q, txs_q, rxs_q};
        OFS_CTRL: rdata_o = {{(DW-1){1'b0}}, en_q};
        OFS_TX:   rdata_o = tx_q;
        OFS_RX:   rdata_o = rx_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mspi_shift.sv
module mspi_shift
  import mspi_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  shift_cfg_t     cfg_i,
  input  logic [DW-1:0]  tx_word_i,
  input  logic [CHW-1:0] ch_i,
  input  logic           miso_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [CHW-1:0] ch_o,
  output logic [DW-1:0]  rx_word_o,
  output logic           sclk_o,
  output logic           mosi_o,
  output logic           pol_o
);
  localparam int unsigned HCW = 15;

  shift_cfg_t     cfg_q;
  logic [DW-1:0]  sh_q, rx_q;
  logic [HCW-1:0] hcnt_q, half_max;
  logic [6:0]     ecnt_q, last_edge;
  logic           busy_q, done_q, sclk_q, leading, smp, shf;
  logic [CHW-1:0] ch_q;

  assign half_max  = HCW'((32'd1 << cfg_q.div) - 32'd1);
  assign last_edge = ({1'b0, cfg_q.len} << 1) - 7'd1;
  assign leading   = !ecnt_q[0];
  assign smp       = cfg_q.cpha ? !leading : leading;
  assign shf       = cfg_q.cpha ? (leading && (ecnt_q != 7'd0)) : !leading;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      hcnt_q <= '0;
      ecnt_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      ch_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cfg_q  <= cfg_i;
          ch_q   <= ch_i;
          sh_q   <= tx_word_i << (7'(DW) - {1'b0, cfg_i.len});
          rx_q   <= '0;
          sclk_q <= cfg_i.cpol;
          hcnt_q <= '0;
          ecnt_q <= '0;
        end
      end else if (hcnt_q == half_max) begin
        hcnt_q <= '0;
        sclk_q <= !sclk_q;
        if (smp) rx_q <= {rx_q[DW-2:0], miso_i};
        if (shf) sh_q <= {sh_q[DW-2:0], 1'b0};
        if (ecnt_q == last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ecnt_q <= ecnt_q + 7'd1;
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ch_o      = ch_q;
  assign rx_word_o = rx_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = sh_q[DW-1];
  assign pol_o     = cfg_q.cpol;
endmodule

// File: rtl/mspi_ctrl.sv
module mspi_ctrl
  import mspi_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [7:0]     req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCH-1:0] cs_o
);
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  shift_cfg_t     chan_cfg [NCH];
  logic [DW-1:0]  chan_tx  [NCH];
  logic [DW-1:0]  chan_rd  [NCH];
  logic [NCH-1:0] chan_req, chan_en, chan_txe, chan_force, chan_low, chan_start;
  logic           eng_busy, eng_done, eng_pol, gnt_any, start;
  logic [CHW-1:0] eng_ch, gnt_idx;
  logic [DW-1:0]  eng_rx, rd_mux;
  logic           mod_single_q, mod_slave_q, mod_test_q;
  logic           rsp_valid_q;
  logic [DW-1:0]  rsp_rdata_q;

  assign req_ready = 1'b1;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam logic [7:0] BASE = 8'(32'(CH0_ADR) + 32'(CH_STRIDE) * g);
    assign chan_start[g] = start && (gnt_idx == CHW'(g));
    mspi_chan #(.DW(DW), .BASE(BASE)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(req_valid), .acc_write(req_write),
      .acc_addr(req_addr), .acc_wdata(req_wdata),
      .start_i(chan_start[g]),
      .done_i(eng_done && (eng_ch == CHW'(g))),
      .rx_word_i(eng_rx),
      .rdata_o(chan_rd[g]), .req_o(chan_req[g]),
      .en_o(chan_en[g]), .txe_o(chan_txe[g]),
      .cfg_o(chan_cfg[g]), .tx_word_o(chan_tx[g]),
      .force_o(chan_force[g]), .lowact_o(chan_low[g])
    );
  end

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (chan_req[i]) begin
        gnt_any = 1'b1;
        gnt_idx = CHW'(i);
      end
    end
  end

  assign start = gnt_any && !eng_busy && !eng_done;

  mspi_shift #(.DW(DW), .CHW(CHW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .cfg_i(chan_cfg[gnt_idx]),
    .tx_word_i(chan_tx[gnt_idx]), .ch_i(gnt_idx),
    .miso_i(miso), .busy_o(eng_busy), .done_o(eng_done),
    .ch_o(eng_ch), .rx_word_o(eng_rx),
    .sclk_o(sclk), .mosi_o(mosi), .pol_o(eng_pol)
  );

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cs_o[i] = (chan_force[i] || (eng_busy && (eng_ch == CHW'(i)))) ^ chan_low[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == MODCTL_ADR) begin
      rd_mux = {{(DW-4){1'b0}}, mod_test_q, mod_slave_q, 1'b0, mod_single_q};
    end else begin
      for (int i = 0; i < NCH; i++) rd_mux = rd_mux | chan_rd[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_single_q <= 1'b0;
      mod_slave_q  <= 1'b0;
      mod_test_q   <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_rdata_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata_q <= rd_mux;
      if (req_valid && req_write && (req_addr == MODCTL_ADR)) begin
        mod_single_q <= req_wdata[0];
        mod_slave_q  <= req_wdata[2];
        mod_test_q   <= req_wdata[3];
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/mspi_ctrl_chk.sv
module mspi_ctrl_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_write,
  input logic           rsp_valid,
  input logic           eng_busy,
  input logic           sclk,
  input logic           eng_pol,
  input logic [CHW-1:0] eng_ch,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] chan_txe
);
  AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R1

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R1

  AST_SCLK_RESTS_AT_POL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |-> (sclk == eng_pol)); // R3

  AST_START_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> ((($past(chan_en) >> eng_ch) & NCH'(1)) != '0)); // R8

  AST_LOAD_EMPTIES_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> (((chan_txe >> eng_ch) & NCH'(1)) != '0)); // R9
endmodule

bind mspi_ctrl mspi_ctrl_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .eng_busy(eng_busy), .sclk(sclk), .eng_pol(eng_pol),
  .eng_ch(eng_ch), .chan_en(chan_en), .chan_txe(chan_txe)
);

// File: tb/tb_mspi_ctrl.sv
module tb_mspi_ctrl;
  localparam int NCH = 4;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, sclk, mosi, miso;
  logic [DW-1:0] rsp_rdata;
  logic [NCH-1:0] cs_o;

  always #4 clk = ~clk;
  assign miso = mosi;

  mspi_ctrl #(.NCH(NCH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  bit rx_pending = 0;
  bit [NCH-1:0] low_b = '0, prev_act = '0;
  int cs_cnt[NCH];
  int tog = 0, overlap = 0;
  int ord_q[$];
  logic sclk_prev = 1'b0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected word for every receive read
  always @(negedge clk) begin
    if (rsp_valid && rx_pending) begin
      rx_pending = 0;
      if (exp_q.size() == 0) check("R9 unexpected rx read", rsp_rdata, '1);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  // serial-side monitor
  always @(negedge clk) begin
    bit [NCH-1:0] act;
    act = cs_o ^ low_b;
    for (int i = 0; i < NCH; i++) begin
      if (act[i]) cs_cnt[i]++;
      if (act[i] && !prev_act[i]) ord_q.push_back(i);
    end
    if ($countones(act) > 1) overlap++;
    prev_act = act;
    if (sclk !== sclk_prev) tog++;
    sclk_prev = sclk;
  end

  function automatic logic [7:0] ca(input int ch, input int off);
    return 8'(44 + ch * 20 + off);
  endfunction

  function automatic logic [31:0] cfgw(input int cpha, input int cpol, input int dv,
                                       input int wlf, input int low, input int md, input int frc);
    return 32'(cpha | (cpol << 1) | (dv << 2) | (low << 6) | (wlf << 7) | (md << 12) | (frc << 20));
  endfunction

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic rd_rx(input int ch);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = ca(ch, 16); rx_pending = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_stat(input int ch, input int bitn);
    logic [DW-1:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(ca(ch, 4), s);
      if (s[bitn]) return;
    end
    check("R9 status flag timeout", 32'(bitn), 32'hFFFF);
  endtask

  task automatic clr_counts();
    for (int i = 0; i < NCH; i++) cs_cnt[i] = 0;
    tog = 0; overlap = 0; ord_q.delete();
  endtask

  task automatic xfer(input int ch, input logic [DW-1:0] tx, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    wr(ca(ch, 12), tx);
    wait_stat(ch, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    rd(ca(0, 4), d); check("R2 stat ch0 reset", d, 32'h2);
    rd(ca(3, 4), d); check("R2 stat ch3 reset", d, 32'h2);
    rd(ca(1, 0), d); check("R2 conf ch1 reset", d, 32'h0);
    rd(ca(2, 8), d); check("R2 ctrl ch2 reset", d, 32'h0);
    check("R6 idle cs after reset", 32'(cs_o), 32'h0);
    check("R1 req_ready", 32'(req_ready), 32'h1);

    // register map
    wr(8'h28, 32'hF); rd(8'h28, d); check("R1 modctl readback", d, 32'hD);
    rd(8'h00, d); check("R1 unmapped read", d, 32'h0);
    wr(ca(2, 0), 32'h0001_2345); rd(ca(2, 0), d); check("R1 ch2 conf readback", d, 32'h0001_2345);
    wr(ca(2, 0), 32'h0);

    // full duplex, phase 0 polarity 0, d=0, L=8
    low_b[0] = 1;
    wr(ca(0, 0), cfgw(0, 0, 0, 7, 1, 0, 0));
    wr(ca(0, 8), 32'h1);
    clr_counts();
    xfer(0, 32'hA5, 32'hA5, "R3 duplex word 0xA5");
    check("R4 cs cycles L8 d0", 32'(cs_cnt[0]), 32'd16);
    check("R3 sclk edges L8", 32'(tog), 32'd16);
    check("R3 sclk idle pol0", 32'(sclk), 32'h0);
    rd(ca(0, 4), d); check("R9 stat after word", d, 32'h7);
    rd_rx(0);
    rd(ca(0, 4), d); check("R9 stat after rx read", d, 32'h6);

    // phase 1 polarity 1, d=2, L=32
    wr(ca(0, 0), cfgw(1, 1, 2, 31, 1, 0, 0));
    clr_counts();
    xfer(0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R3 phase1 pol1 32-bit word");
    check("R4 cs cycles L32 d2", 32'(cs_cnt[0]), 32'd256);
    check("R3 sclk idle pol1", 32'(sclk), 32'h1);
    rd_rx(0);

    // word length
    wr(ca(0, 0), cfgw(0, 0, 1, 11, 1, 0, 0));
    xfer(0, 32'hFFFF_F123, 32'h123, "R5 12-bit right-justified");
    rd_rx(0);
    wr(ca(0, 0), cfgw(0, 0, 0, 0, 1, 0, 0));
    clr_counts();
    xfer(0, 32'hAB, 32'hB, "R5 short field gives 4 bits");
    check("R5 cs cycles for 4-bit word", 32'(cs_cnt[0]), 32'd8);
    rd_rx(0);

    // transmit-only
    wr(ca(0, 0), cfgw(0, 0, 0, 7, 1, 2, 0));
    wr(ca(0, 12), 32'h5A);
    wait_stat(0, 2);
    rd(ca(0, 4), d); check("R10 tx-only no rx ready", d, 32'h6);
    rd(ca(0, 16), d); check("R10 tx-only rx reg kept", d, 32'hB);

    // disabled channel
    wr(ca(0, 0), cfgw(0, 0, 0, 7, 1, 0, 0));
    wr(ca(0, 8), 32'h0);
    clr_counts();
    wr(ca(0, 12), 32'h11);
    repeat (50) @(negedge clk);
    check("R8 no cs while disabled", 32'(cs_cnt[0]), 32'd0);
    rd(ca(0, 4), d); check("R8 stat pending while disabled", d, 32'h0);
    exp_q.push_back(32'h11); tag_q.push_back("R8 word runs after enable");
    wr(ca(0, 8), 32'h1);
    wait_stat(0, 0);
    rd_rx(0);

    // chip-select polarity and force
    wr(ca(0, 0), cfgw(0, 0, 0, 7, 1, 0, 1));
    check("R7 forced active-low cs", 32'(cs_o[0]), 32'h0);
    repeat (20) @(negedge clk);
    check("R7 force holds", 32'(cs_o[0]), 32'h0);
    wr(ca(0, 0), cfgw(0, 0, 0, 7, 1, 0, 0));
    check("R6 active-low idle level", 32'(cs_o[0]), 32'h1);
    wr(ca(1, 0), cfgw(0, 0, 0, 7, 0, 0, 0));
    check("R6 active-high idle level", 32'(cs_o[1]), 32'h0);
    wr(ca(1, 0), cfgw(0, 0, 0, 7, 0, 0, 1));
    check("R7 forced active-high cs", 32'(cs_o[1]), 32'h1);

    // receive-only
    wr(ca(0, 0), cfgw(0, 0, 0, 7, 1, 1, 0));
    exp_q.push_back(32'h3C); tag_q.push_back("R10 rx-only first word");
    exp_q.push_back(32'h3C); tag_q.push_back("R10 rx-only second word");
    wr(ca(0, 12), 32'h3C);
    wait_stat(0, 0); rd_rx(0);
    wait_stat(0, 0); rd_rx(0);
    wr(ca(0, 8), 32'h0);
    repeat (40) @(negedge clk);
    clr_counts();
    repeat (60) @(negedge clk);
    check("R10 rx-only stops when disabled", 32'(cs_cnt[0]), 32'd0);

    // arbitration
    low_b[1] = 1; low_b[2] = 1;
    wr(ca(0, 0), cfgw(0, 0, 3, 31, 1, 0, 0));
    wr(ca(1, 0), cfgw(0, 0, 0, 7, 1, 0, 0));
    wr(ca(2, 0), cfgw(0, 0, 0, 7, 1, 0, 0));
    wr(ca(0, 8), 32'h1); wr(ca(1, 8), 32'h1); wr(ca(2, 8), 32'h1);
    repeat (2) @(negedge clk);
    clr_counts();
    wr(ca(0, 12), 32'h1234_5678);
    wr(ca(2, 12), 32'h22);
    wr(ca(1, 12), 32'h11);
    wait_stat(2, 2);
    check("R11 activations", 32'(ord_q.size()), 32'd3);
    if (ord_q.size() == 3) begin
      check("R11 first channel", 32'(ord_q[0]), 32'd0);
      check("R11 lowest pending next", 32'(ord_q[1]), 32'd1);
      check("R11 higher last", 32'(ord_q[2]), 32'd2);
    end
    check("R11 no overlapping cs", 32'(overlap), 32'd0);
    check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule